// File: doc/BRIEF.md
# Transaction Ordering Gate for One Bridge Direction

The gate holds the transactions waiting to leave a bridge in one direction and decides, every cycle, which of them may be offered to the outbound bus next. Each waiting transaction carries a class and a tag. There are five classes:

- posted write: memory write and memory write-and-invalidate;
- delayed read request: memory, I/O and configuration reads;
- delayed write request: I/O writes, configuration writes and writes to designated memory locations;
- delayed read completion;
- delayed write completion.

The gate keeps its entries in age order. It offers the oldest entry that the ordering rules allow, and it releases a slot only when the issued transaction is reported finished.

The rules centre on posted writes. While an older posted write is still held, whether it has been issued or not, the gate never offers another posted write, a delayed read request, a delayed write request or a delayed read completion. Delayed write completions are exempt and may go ahead. A posted write may overtake older delayed traffic of any class.

A producer pushes entries through a valid/ready port. The bus side takes a grant with `gnt_accept`, after which the entry counts as issued. It names the finished transaction later with `done_valid` and `done_tag`. Tags must be unique among the entries held.

Top module: `ordq_gate`

## Requirements
- R1: After reset no grant is offered and `push_ready` is high.
- R2: The gate holds at most DEPTH entries. `push_ready` is low exactly when all DEPTH slots are occupied, and a push made while it is low is discarded.
- R3: While a grant is offered and neither `gnt_accept` nor `done_valid` is asserted, the grant stays valid with the same tag in the next cycle.
- R4: A posted write (class code 0) is never offered while an older posted write is held, issued or not.
- R5: A delayed read request (code 1), a delayed write request (code 2) or a delayed read completion (code 3) is never offered while an older posted write is held.
- R6: A delayed write completion (code 4) may be offered ahead of older posted writes. A posted write may be offered ahead of older entries of codes 1 to 4.
- R7: The offered entry is the oldest held entry that is not yet issued and that R4 and R5 allow. An accepted entry is not offered again.
- R8: An issued entry keeps its slot until `done_valid` names its tag. It is then removed, its slot is freed and any block it imposed is lifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | New entry presented |
| push_ready | output | 1 | A free slot exists |
| push_cls | input | 3 | Class code of the new entry (0..4) |
| push_tag | input | TAG_W | Tag of the new entry |
| gnt_valid | output | 1 | An entry is offered for issue |
| gnt_cls | output | 3 | Class code of the offered entry |
| gnt_tag | output | TAG_W | Tag of the offered entry |
| gnt_accept | input | 1 | The offered entry is taken this cycle |
| done_valid | input | 1 | An issued entry has finished |
| done_tag | input | TAG_W | Tag of the finished entry |

## Verification
The hardest state to reach is one where the offer depends on an entry that has already been issued but is not yet finished. An example is a read held back by a posted write that is in flight, while a younger completion is allowed past it.

The bench reaches this state by pushing every ordered triple of the five classes and accepting the oldest entry without finishing it. It then compares the next offer with an age-ordered pass model. Finally it finishes the oldest entry and checks that the block it imposed is gone.

// File: rtl/ordq_pkg.sv
package ordq_pkg;

    typedef enum logic [2:0] {
        CL_PW  = 3'd0,
        CL_DRR = 3'd1,
        CL_DWR = 3'd2,
        CL_DRC = 3'd3,
        CL_DWC = 3'd4
    } ordq_cls_e;

    // May an entry of class newer be offered while an entry of class older is held ahead of it?
    function automatic logic may_pass(ordq_cls_e newer, ordq_cls_e older);
        return !(older == CL_PW && newer != CL_DWC);
    endfunction

endpackage

// File: rtl/ordq_pick.sv
module ordq_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     oh_o
);

    // Lowest index wins: slot 0 is the oldest.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        oh_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
                oh_o  = N'(1) << i;
            end
        end
    end

endmodule

// File: rtl/ordq_elig.sv
module ordq_elig
    import ordq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] vld_i,
    input  ordq_cls_e        cls_i [DEPTH],
    output logic [DEPTH-1:0] elig_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic blocked;
        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < g; j++) begin
                if (vld_i[j] && !may_pass(cls_i[g], cls_i[j])) begin
                    blocked = 1'b1;
                end
            end
            elig_o[g] = !blocked;
        end
    end

endmodule

// File: rtl/ordq_gate.sv
module ordq_gate
    import ordq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic [2:0]       push_cls,
    input  logic [TAG_W-1:0] push_tag,
    output logic             gnt_valid,
    output logic [2:0]       gnt_cls,
    output logic [TAG_W-1:0] gnt_tag,
    input  logic             gnt_accept,
    input  logic             done_valid,
    input  logic [TAG_W-1:0] done_tag
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             vld;
        logic             iss;
        ordq_cls_e        cls;
        logic [TAG_W-1:0] tag;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic  [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0] vld_v, elig_v, gnt_req, done_req, gnt_oh, done_oh;
    ordq_cls_e        cls_v [DEPTH];
    logic             gnt_hit, done_hit;
    logic [IDX_W-1:0] gnt_idx, done_idx;

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            vld_v[k]    = st_q.slot[k].vld;
            cls_v[k]    = st_q.slot[k].cls;
            gnt_req[k]  = st_q.slot[k].vld && !st_q.slot[k].iss && elig_v[k];
            done_req[k] = st_q.slot[k].vld && st_q.slot[k].iss
                          && (st_q.slot[k].tag == done_tag);
        end
    end

    ordq_elig #(.DEPTH(DEPTH)) u_elig (
        .vld_i  (vld_v),
        .cls_i  (cls_v),
        .elig_o (elig_v)
    );

    ordq_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick_gnt (
        .req_i (gnt_req),
        .hit_o (gnt_hit),
        .idx_o (gnt_idx),
        .oh_o  (gnt_oh)
    );

    ordq_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick_done (
        .req_i (done_req),
        .hit_o (done_hit),
        .idx_o (done_idx),
        .oh_o  (done_oh)
    );

    assign push_ready = (st_q.cnt < CNT_W'(DEPTH));
    assign gnt_valid  = gnt_hit;
    assign gnt_cls    = st_q.slot[gnt_idx].cls;
    assign gnt_tag    = st_q.slot[gnt_idx].tag;

    always_comb begin
        slot_t [DEPTH-1:0] s_acc;
        slot_t [DEPTH-1:0] s_rem;
        logic  [CNT_W-1:0] c_rem;

        s_acc = st_q.slot;
        if (gnt_hit && gnt_accept) begin
            s_acc[gnt_idx].iss = 1'b1;
        end

        s_rem = s_acc;
        c_rem = st_q.cnt;
        if (done_valid && done_hit) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                if (k >= int'(done_idx)) begin
                    s_rem[k] = s_acc[k + 1];
                end
            end
            s_rem[DEPTH-1] = '0;
            c_rem          = c_rem - CNT_W'(1);
        end

        if (push_valid && push_ready) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (CNT_W'(k) == c_rem) begin
                    s_rem[k].vld = 1'b1;
                    s_rem[k].iss = 1'b0;
                    s_rem[k].cls = ordq_cls_e'(push_cls);
                    s_rem[k].tag = push_tag;
                end
            end
            c_rem = c_rem + CNT_W'(1);
        end

        st_d.slot = s_rem;
        st_d.cnt  = c_rem;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: occupancy never exceeds the slot count
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R2: a push refused for lack of room leaves occupancy unchanged
    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !push_ready && !done_valid |=> st_q.cnt == $past(st_q.cnt));

    // R3: an untaken offer persists
    a_r3_grant_steady: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid && !gnt_accept && !done_valid |=> gnt_valid && gnt_tag == $past(gnt_tag));

    // R7: at most one slot is chosen
    a_r7_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh) && $onehot0(done_oh));

    // R8: a finish report names an issued entry and frees exactly one slot
    a_r8_done_known: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_hit);

    a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !push_valid |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1));

endmodule

// File: tb/test_ordq_gate.sv
module test_ordq_gate;

    localparam int DEPTH = 4;
    localparam int TAG_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic             push_ready;
    logic [2:0]       push_cls = '0;
    logic [TAG_W-1:0] push_tag = '0;
    logic             gnt_valid;
    logic [2:0]       gnt_cls;
    logic [TAG_W-1:0] gnt_tag;
    logic             gnt_accept = 1'b0;
    logic             done_valid = 1'b0;
    logic [TAG_W-1:0] done_tag = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ordq_gate #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_ordq_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_cls   (push_cls),
        .push_tag   (push_tag),
        .gnt_valid  (gnt_valid),
        .gnt_cls    (gnt_cls),
        .gnt_tag    (gnt_tag),
        .gnt_accept (gnt_accept),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_push(int c, int t);
        @(negedge clk);
        push_valid = 1'b1;
        push_cls   = 3'(c);
        push_tag   = TAG_W'(t);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic do_accept();
        @(negedge clk);
        gnt_accept = 1'b1;
        @(negedge clk);
        gnt_accept = 1'b0;
    endtask

    task automatic do_done(int t);
        @(negedge clk);
        done_valid = 1'b1;
        done_tag   = TAG_W'(t);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3 * DEPTH; i++) begin
            int tg;
            #1;
            if (!gnt_valid) break;
            tg = int'(gnt_tag);
            do_accept();
            do_done(tg);
        end
    endtask

    // Reference rule: class 0 holds back every younger class except 4.
    function automatic bit ref_pass(int newer, int older);
        return !(older == 0 && newer != 4);
    endfunction

    // Oldest held, unissued entry that every older held entry lets pass; -1 if none.
    function automatic int ref_pick(int n, int c0, int c1, int c2, bit i0, bit i1, bit i2);
        int cl[3];
        bit is[3];
        cl[0] = c0; cl[1] = c1; cl[2] = c2;
        is[0] = i0; is[1] = i1; is[2] = i2;
        for (int i = 0; i < n; i++) begin
            bit ok = !is[i];
            for (int j = 0; j < i; j++) begin
                if (!ref_pass(cl[i], cl[j])) ok = 0;
            end
            if (ok) return i;
        end
        return -1;
    endfunction

    function automatic string tag_of(int newer, int older);
        if (older != 0) return "R6";
        if (newer == 0) return "R4";
        if (newer == 4) return "R6";
        return "R5";
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "gnt_valid after reset", int'(gnt_valid), 0);
        chk("R1", "push_ready after reset", int'(push_ready), 1);

        // Every ordered triple: offer with the oldest in flight, then after it finishes.
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                for (int c = 0; c < 5; c++) begin
                    int e;
                    do_push(a, 0);
                    do_push(b, 1);
                    do_push(c, 2);
                    #1;
                    chk("R7", "first offer tag", int'(gnt_tag), 0);
                    do_accept();
                    #1;
                    e = ref_pick(3, a, b, c, 1, 0, 0);
                    chk(tag_of(e < 0 ? b : (e == 1 ? b : c), a), "offer valid with oldest in flight",
                        int'(gnt_valid), int'(e >= 0));
                    if (e >= 0) chk("R7", "offer tag with oldest in flight", int'(gnt_tag), e);
                    do_done(0);
                    #1;
                    chk("R8", "offer valid after oldest finished", int'(gnt_valid), 1);
                    chk("R8", "offer tag after oldest finished", int'(gnt_tag), 1);
                    drain();
                    #1;
                    chk("R8", "empty after drain", int'(gnt_valid), 0);
                    chk("R8", "ready after drain", int'(push_ready), 1);
                end
            end
        end

        // R3: untaken offer persists; R6: completion slips past an in-flight posted write.
        do_push(0, 1);
        do_push(1, 2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R3", "steady offer tag", int'(gnt_tag), 1);
        end
        do_push(4, 3);
        do_accept();
        #1;
        chk("R6", "completion offered past posted write", int'(gnt_tag), 3);
        do_accept();
        #1;
        chk("R5", "read request held by posted write", int'(gnt_valid), 0);
        do_done(1);
        #1;
        chk("R8", "read released after posted write finishes", int'(gnt_tag), 2);
        do_done(3);
        drain();

        // R2: capacity, refusal and discarded push; R8: issued entry keeps its slot.
        for (int t = 4; t < 4 + DEPTH; t++) do_push(1, t);
        #1;
        chk("R2", "ready when full", int'(push_ready), 0);
        do_push(2, 12);
        do_accept();
        #1;
        chk("R8", "ready while issued entry unfinished", int'(push_ready), 0);
        do_done(4);
        #1;
        chk("R8", "ready after finish", int'(push_ready), 1);
        for (int t = 5; t < 4 + DEPTH; t++) begin
            #1;
            chk("R2", "drain order tag", int'(gnt_tag), t);
            do_accept();
            do_done(t);
        end
        #1;
        chk("R2", "discarded push never offered", int'(gnt_valid), 0);

        finish_run();
    end

endmodule